// File: doc/BRIEF.md
# Return-from-Interrupt Machine State Restore Unit

When a return-from-interrupt instruction completes, this unit works out the new 64-bit machine state register (MSR) and the next instruction address (NIA). It takes three values: the current MSR, the saved machine state (SRR1) and the saved return address (SRR0). The new MSR is not a plain copy of the saved state. The hypervisor, machine-check-enable and transactional-state bits follow conditional rules that look at both the current and the saved state. The interrupt-enable and the two relocation bits are forced on whenever the saved state has problem state (user mode) set. Every other bit comes straight from SRR1. The new NIA is SRR0 cleared to a word boundary.

Bits are named in big-endian order. Architectural bit n of a 64-bit register sits at LSB index 63-n. Every position below is given both ways. The result is held in one registered output stage with a valid/ready handshake. A context tag travels with each operation so that the result can be matched to the instruction that issued it. Each result carries two write-enable flags, one for the MSR and one for the NIA.

Top module: `rfi_msr_unit`

## Requirements
- R1: New MSR hypervisor bit (arch 3, LSB 60) is the AND of the current MSR bit and the SRR1 bit at that position.
- R2: New MSR machine-check-enable bit (arch 51, LSB 12) is taken from SRR1 when the current MSR hypervisor bit (LSB 60) is 1, and keeps the current MSR value when it is 0.
- R3: The transactional-state field (arch 29..31, LSB 34..32, arch 29 being the MSB) keeps the current MSR value only when the current field is 3'b010 and the SRR1 field is 3'b000. In every other case it is taken from SRR1.
- R4: The new interrupt-enable (arch 48, LSB 15), instruction-relocate (arch 58, LSB 5) and data-relocate (arch 59, LSB 4) bits are each the OR of the matching SRR1 bit and the SRR1 problem-state bit (arch 49, LSB 14).
- R5: Every MSR bit not named in R1 to R4 is copied from the same position of SRR1. This includes the problem-state bit and arch bits 33..36.
- R6: The new NIA equals SRR0 with LSB bits 1:0 cleared.
- R7: An input accepted with in_valid and in_ready both high appears on the outputs on the next clock edge. At that point out_valid, out_msr_ok and out_nia_ok are 1 and out_ctx equals the accepted tag.
- R8: After reset, and in any cycle with no result held, out_valid and both ok flags are 0. While a result is held with out_ready low, it stays unchanged and in_ready is 0. in_ready equals (not out_valid) or out_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_ctx | input | CTX_W | Tag of the issuing instruction |
| in_msr | input | 64 | Current machine state |
| in_srr0 | input | 64 | Saved return address |
| in_srr1 | input | 64 | Saved machine state |
| out_ready | input | 1 | Consumer takes the held result |
| out_valid | output | 1 | A result is held |
| out_ctx | output | CTX_W | Tag of the held result |
| out_msr | output | 64 | New machine state |
| out_msr_ok | output | 1 | Write enable for the new machine state |
| out_nia | output | 64 | New instruction address |
| out_nia_ok | output | 1 | Write enable for the new instruction address |

## Verification
The hardest case to reach is the narrow keep condition of the transactional-state field. It needs one exact pattern in the current MSR and another exact pattern in SRR1 at the same time, and random 64-bit words hit that pair only about once in 64 draws. The bench therefore sweeps every combination of the fields that the rules look at: both hypervisor bits, both machine-check bits, problem state, the three forced bits, and both 3-bit transactional fields. The remaining bits are filled with random values, so the keep pattern is met under every hypervisor setting, and problem state is met with the forced bits both clear and set. A separate directed sequence holds a result under back-pressure while a second operation waits, then releases it.

// File: rtl/rfi_pkg.sv
// Package: bit positions and per-bit source classes for the machine state restore.
// Assumes a 64-bit register with big-endian (architectural) bit numbering.
package rfi_pkg;

    localparam int XLEN = 64;

    // Architectural (big-endian) positions of the bits with special rules
    localparam int A_HV    = 3;
    localparam int A_TS_HI = 29;
    localparam int A_TS_LO = 31;
    localparam int A_EE    = 48;
    localparam int A_PR    = 49;
    localparam int A_ME    = 51;
    localparam int A_IR    = 58;
    localparam int A_DR    = 59;

    // The same positions as LSB indices
    localparam int L_HV    = XLEN - 1 - A_HV;
    localparam int L_PR    = XLEN - 1 - A_PR;
    localparam int L_ME    = XLEN - 1 - A_ME;
    localparam int L_TS_HI = XLEN - 1 - A_TS_HI;
    localparam int L_TS_LO = XLEN - 1 - A_TS_LO;
    localparam int TS_W    = L_TS_HI - L_TS_LO + 1;

    // Field patterns that together keep the current transactional state
    localparam logic [TS_W-1:0] TS_KEEP_CUR   = 3'b010;
    localparam logic [TS_W-1:0] TS_KEEP_SAVED = 3'b000;

    // How one bit of the new machine state is sourced
    typedef enum logic [2:0] {
        SRC_COPY,    // straight from saved state
        SRC_HV_AND,  // current AND saved
        SRC_ME_SEL,  // saved if current hypervisor, else current
        SRC_TS_SEL,  // transactional field keep/replace rule
        SRC_PR_OR    // saved OR saved problem state
    } src_e;

    // Classify an architectural bit number
    function automatic src_e src_of(input int arch);
        if (arch == A_HV)                         return SRC_HV_AND;
        if (arch == A_ME)                         return SRC_ME_SEL;
        if (arch >= A_TS_HI && arch <= A_TS_LO)   return SRC_TS_SEL;
        if (arch == A_EE || arch == A_IR || arch == A_DR) return SRC_PR_OR;
        return SRC_COPY;
    endfunction

endpackage

// File: rtl/rfi_msr_merge.sv
// Module: rfi_msr_merge
// Combinational merge of current and saved machine state into the new state.
// Each bit is a 2:1 choice between the current bit and an alternative built
// from the saved state; the class of the bit decides both selector and
// alternative. Assumes rfi_pkg::XLEN wide operands.
module rfi_msr_merge
    import rfi_pkg::*;
(
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] saved_msr,
    output logic [XLEN-1:0] new_msr
);

    logic [XLEN-1:0] pick_cur;   // 1: take current bit
    logic [XLEN-1:0] alt_bit;    // value used when pick_cur is 0
    logic            ts_hold;    // transactional field keeps current value
    logic            cur_hv;
    logic            saved_pr;

    // Purpose: decode the shared conditions used by several bits
    always_comb begin
        cur_hv   = cur_msr[L_HV];
        saved_pr = saved_msr[L_PR];
        ts_hold  = (cur_msr[L_TS_HI:L_TS_LO]   == TS_KEEP_CUR) &&
                   (saved_msr[L_TS_HI:L_TS_LO] == TS_KEEP_SAVED);
    end

    // One selector/alternative pair per bit, chosen by its class
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        localparam src_e CLS = src_of(XLEN - 1 - i);
        if (CLS == SRC_HV_AND) begin : g_hv
            assign pick_cur[i] = saved_msr[i];
            assign alt_bit[i]  = 1'b0;
        end else if (CLS == SRC_ME_SEL) begin : g_me
            assign pick_cur[i] = ~cur_hv;
            assign alt_bit[i]  = saved_msr[i];
        end else if (CLS == SRC_TS_SEL) begin : g_ts
            assign pick_cur[i] = ts_hold;
            assign alt_bit[i]  = saved_msr[i];
        end else if (CLS == SRC_PR_OR) begin : g_pr
            assign pick_cur[i] = 1'b0;
            assign alt_bit[i]  = saved_msr[i] | saved_pr;
        end else begin : g_cp
            assign pick_cur[i] = 1'b0;
            assign alt_bit[i]  = saved_msr[i];
        end
    end

    // Purpose: final per-bit selection
    always_comb begin
        new_msr = (pick_cur & cur_msr) | (~pick_cur & alt_bit);
    end

endmodule

// File: rtl/rfi_nia_align.sv
// Module: rfi_nia_align
// Produces the return address aligned down to ALIGN_BITS low zero bits.
// Assumes ALIGN_BITS < W.
module rfi_nia_align #(
    parameter int W          = 64,
    parameter int ALIGN_BITS = 2
) (
    input  logic [W-1:0] ret_addr,
    output logic [W-1:0] nia
);

    localparam logic [W-1:0] LOW_MASK = (W'(1) << ALIGN_BITS) - W'(1);

    // Purpose: clear the low address bits
    always_comb begin
        nia = ret_addr & ~LOW_MASK;
    end

endmodule

// File: rtl/rfi_out_stage.sv
// Module: rfi_out_stage
// One-entry registered output stage with valid/ready on both sides.
// Accepts a new payload when empty or when the held payload is taken.
module rfi_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);

    // Purpose: can accept when nothing is held or the holder is drained
    always_comb begin
        up_ready = ~dn_valid | dn_ready;
    end

    // Purpose: valid flag and payload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
            if (up_valid) dn_data <= up_data;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data)); // R8

endmodule

// File: rtl/rfi_msr_unit.sv
// Module: rfi_msr_unit (top)
// Computes new machine state and next instruction address for a
// return-from-interrupt, with one registered output stage. The context tag
// travels with the result. Assumes 64-bit registers, big-endian bit numbers.
module rfi_msr_unit #(
    parameter int CTX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [CTX_W-1:0]          in_ctx,
    input  logic [rfi_pkg::XLEN-1:0]  in_msr,
    input  logic [rfi_pkg::XLEN-1:0]  in_srr0,
    input  logic [rfi_pkg::XLEN-1:0]  in_srr1,
    input  logic                      out_ready,
    output logic                      out_valid,
    output logic [CTX_W-1:0]          out_ctx,
    output logic [rfi_pkg::XLEN-1:0]  out_msr,
    output logic                      out_msr_ok,
    output logic [rfi_pkg::XLEN-1:0]  out_nia,
    output logic                      out_nia_ok
);
    import rfi_pkg::*;

    localparam int PAY_W = CTX_W + 2 * XLEN;
    localparam int L_EE  = XLEN - 1 - A_EE;
    localparam int L_IR  = XLEN - 1 - A_IR;
    localparam int L_DR  = XLEN - 1 - A_DR;

    logic [XLEN-1:0]  nxt_msr;
    logic [XLEN-1:0]  nxt_nia;
    logic [PAY_W-1:0] pay_in;
    logic [PAY_W-1:0] pay_out;

    rfi_msr_merge u_merge (
        .cur_msr   (in_msr),
        .saved_msr (in_srr1),
        .new_msr   (nxt_msr)
    );

    rfi_nia_align #(.W(XLEN), .ALIGN_BITS(2)) u_align (
        .ret_addr (in_srr0),
        .nia      (nxt_nia)
    );

    // Purpose: pack the result with its tag
    always_comb begin
        pay_in = {in_ctx, nxt_msr, nxt_nia};
    end

    rfi_out_stage #(.W(PAY_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (pay_in),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (pay_out)
    );

    // Purpose: unpack held result; both write enables follow a held result
    always_comb begin
        {out_ctx, out_msr, out_nia} = pay_out;
        out_msr_ok = out_valid;
        out_nia_ok = out_valid;
    end

    logic accepted;
    assign accepted = in_valid & in_ready;

    AST_HV_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> !out_msr[L_HV] || $past(in_msr[L_HV])); // R1

    AST_ME_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && !in_msr[L_HV] |=> out_msr[L_ME] == $past(in_msr[L_ME])); // R2

    AST_PR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> !out_msr[L_PR] || (out_msr[L_EE] && out_msr[L_IR] && out_msr[L_DR])); // R4

    AST_NIA_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_nia[1:0] == 2'b00); // R6

    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> out_valid && out_msr_ok && out_nia_ok && out_ctx == $past(in_ctx)); // R7

    AST_IDLE_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_msr_ok && !out_nia_ok); // R8

endmodule

// File: tb/sim_rfi_msr_unit.sv
module sim_rfi_msr_unit;

    localparam int CW = 8;

    // LSB indices of the fields, from the requirement text
    localparam int HV = 60, ME = 12, EE = 15, PR = 14, IR = 5, DR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [CW-1:0] in_ctx = '0;
    logic [63:0]   in_msr = '0, in_srr0 = '0, in_srr1 = '0;
    logic          out_ready = 1'b1;
    logic          out_valid;
    logic [CW-1:0] out_ctx;
    logic [63:0]   out_msr, out_nia;
    logic          out_msr_ok, out_nia_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    rfi_msr_unit #(.CTX_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctx(in_ctx), .in_msr(in_msr), .in_srr0(in_srr0), .in_srr1(in_srr1),
        .out_ready(out_ready), .out_valid(out_valid), .out_ctx(out_ctx),
        .out_msr(out_msr), .out_msr_ok(out_msr_ok), .out_nia(out_nia),
        .out_nia_ok(out_nia_ok)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Expected new machine state, written from the requirement text
    function automatic logic [63:0] ref_msr(input logic [63:0] m, input logic [63:0] s);
        logic [63:0] e;
        e     = s;                                    // R5 default
        e[HV] = m[HV] & s[HV];                        // R1
        e[ME] = m[HV] ? s[ME] : m[ME];                // R2
        if (m[34:32] == 3'b010 && s[34:32] == 3'b000) // R3
            e[34:32] = m[34:32];
        e[EE] = s[EE] | s[PR];                        // R4
        e[IR] = s[IR] | s[PR];
        e[DR] = s[DR] | s[PR];
        return e;
    endfunction

    task automatic check_result(input logic [63:0] m, input logic [63:0] s,
                                input logic [63:0] r0, input logic [CW-1:0] c);
        logic [63:0] e;
        e = ref_msr(m, s);
        chk(out_msr[HV] == e[HV], "R1 hv", 64'(out_msr[HV]), 64'(e[HV]));
        chk(out_msr[ME] == e[ME], "R2 me", 64'(out_msr[ME]), 64'(e[ME]));
        chk(out_msr[34:32] == e[34:32], "R3 ts", 64'(out_msr[34:32]), 64'(e[34:32]));
        chk({out_msr[EE], out_msr[IR], out_msr[DR]} == {e[EE], e[IR], e[DR]},
            "R4 ee/ir/dr", out_msr, e);
        chk(out_msr == e, "R5 msr", out_msr, e);
        chk(out_nia == {r0[63:2], 2'b00}, "R6 nia", out_nia, {r0[63:2], 2'b00});
        chk(out_valid && out_msr_ok && out_nia_ok && out_ctx == c, "R7 flags/ctx",
            {out_valid, out_msr_ok, out_nia_ok, 53'd0, out_ctx},
            {3'b111, 53'd0, c});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin : stim
        logic [63:0] m, s, r0, ma, sa, ra;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!out_valid && !out_msr_ok && !out_nia_ok && in_ready, "R8 reset",
            {60'd0, out_valid, out_msr_ok, out_nia_ok, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every combination of the rule-relevant fields
        for (int c = 0; c < 16384; c++) begin
            logic [13:0] k;
            k = 14'(c);
            m  = {$urandom, $urandom};
            s  = {$urandom, $urandom};
            r0 = {$urandom, $urandom};
            m[HV] = k[0];  s[HV] = k[1];  s[PR] = k[2];
            s[EE] = k[3];  s[IR] = k[4];  s[DR] = k[5];
            m[ME] = k[6];  s[ME] = k[7];
            m[34:32] = k[10:8];
            s[34:32] = k[13:11];
            in_msr = m; in_srr1 = s; in_srr0 = r0; in_ctx = CW'(c);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_result(m, s, r0, CW'(c));
        end
        @(negedge clk);
        chk(!out_valid && !out_msr_ok && !out_nia_ok, "R8 idle",
            {61'd0, out_valid, out_msr_ok, out_nia_ok}, 64'd0);

        // Back-pressure: hold result A while B waits
        out_ready = 1'b0;
        ma = {$urandom, $urandom}; sa = {$urandom, $urandom}; ra = {$urandom, $urandom};
        sa[PR] = 1'b1; sa[EE] = 1'b0; sa[IR] = 1'b0; sa[DR] = 1'b0;
        in_msr = ma; in_srr1 = sa; in_srr0 = ra; in_ctx = 8'hA5; in_valid = 1'b1;
        @(negedge clk);
        check_result(ma, sa, ra, 8'hA5);
        m = {$urandom, $urandom}; s = {$urandom, $urandom}; r0 = {$urandom, $urandom};
        m[34:32] = 3'b010; s[34:32] = 3'b000;
        in_msr = m; in_srr1 = s; in_srr0 = r0; in_ctx = 8'h3C;
        for (int w = 0; w < 3; w++) begin
            chk(!in_ready, "R8 ready low while held", 64'(in_ready), 64'd0);
            @(negedge clk);
            chk(out_msr == ref_msr(ma, sa) && out_ctx == 8'hA5, "R8 held stable",
                out_msr, ref_msr(ma, sa));
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_result(m, s, r0, 8'h3C);
        @(negedge clk);
        chk(!out_valid && !out_msr_ok && !out_nia_ok, "R8 drained",
            {61'd0, out_valid, out_msr_ok, out_nia_ok}, 64'd0);

        done = 1;
        finish_up();
    end

endmodule